// File: doc/BRIEF.md
# Buffered Shuffle-Exchange Packet Router

This block is a synchronous N-by-N packet fabric, with N a power of two and 8 by default. It has log2(N) stages. Each stage holds N/2 two-by-two switching elements, and a perfect-shuffle wiring sits ahead of every stage. Each input port takes a packet made of a destination address and a payload, under a valid/ready handshake. The address acts as the routing tag. Each stage consumes one address bit, most significant bit first. One pass through the stages lands the packet on the output port whose index equals its address.

Each element has a two-slot queue on each of its inputs. The queue is a small state machine with three states: `SLOT_EMPTY`, `SLOT_ONE` and `SLOT_FULL`.
- It moves from `SLOT_EMPTY` to `SLOT_ONE` on a push.
- It moves from `SLOT_ONE` to `SLOT_FULL` on a push without a pop.
- It moves from `SLOT_ONE` to `SLOT_EMPTY` on a pop without a push.
- It moves from `SLOT_FULL` to `SLOT_ONE` on a pop.
- It stays where it is in all other cases.

A full queue drops its ready, so the stage before it holds its packet.

When both queue heads of an element ask for the same output link, a preference state machine picks the winner. It has two states, `PREF_UPPER` and `PREF_LOWER`, and it flips to the other state on every contested grant that the downstream side accepts. The losing packet stays at its queue head and is offered again on the following clocks. Outputs are registered and carry a valid flag with no back-pressure, because every output port is always drained.

Top module: `sen_network`

## Requirements
- R1: A packet accepted at any input with address d appears only on output port d. Outputs never stall.
- R2: With no other traffic, out_valid for a packet rises exactly log2(N) rising clock edges after the edge that accepted it. It stays high for one cycle only.
- R3: Stage k routes on address bit (log2(N)-1-k). A 0 takes the element's upper link (even line) and a 1 takes the lower link (odd line).
- R4: An input packet is taken only on an edge where its in_valid and in_ready are both high. With in_valid low, nothing enters the fabric.
- R5: Every element input has a two-slot queue. When the queue is full, its ready is low and the stage before it keeps offering the same packet.
- R6: Inputs i and i+N/2 meet at stage-0 element i, with input i on the upper side. After reset the upper side wins a tie. The preference flips after each contested grant that is taken, so repeated ties alternate winners.
- R7: A packet that loses a tie is not dropped. It is delivered on a later cycle.
- R8: Packets from one input to one output leave in the order they entered, with none lost and none duplicated.
- R9: After reset, every out_valid is low, every in_ready is high, and every element prefers its upper input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all stages |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N | Packet present, one bit per input |
| in_ready | output | N | Input queue has room, one bit per input |
| in_dest | input | N*log2(N) | Destination address per input, packed by input index |
| in_data | input | N*W | Payload per input, packed by input index |
| out_valid | output | N | Packet delivered, one bit per output |
| out_data | output | N*W | Delivered payload per output, packed by output index |

## Verification
Faults in the internal state show at the ports within a few cycles.
- A queue that loses or repeats an entry shows up, on the next delivery from that input/output pair, as a missing, extra or out-of-order payload.
- A wrong tag bit or a wrong shuffle tap puts the payload on the wrong port at exactly log2(N) edges after acceptance.
- A preference that fails to flip shows up in the second of two back-to-back ties: the same source wins both, instead of the other source winning the second.
- A ready that does not drop when a queue is full becomes a lost packet under hot-spot traffic.

// File: rtl/sen_pkg.sv
package sen_pkg;

    // Occupancy of a two-slot element input queue
    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_ONE   = 2'd1,
        SLOT_FULL  = 2'd2
    } slot_state_t;

    // Which input of an element wins a tie
    typedef enum logic {
        PREF_UPPER = 1'b0,
        PREF_LOWER = 1'b1
    } pref_t;

    // Stage input position q is fed by line rotate-right(q) of the previous lane
    function automatic int shuffle_src(input int q, input int aw);
        return (q >> 1) | ((q & 1) << (aw - 1));
    endfunction

endpackage

// File: rtl/sen_fifo2.sv
module sen_fifo2 #(
    parameter int PW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    output logic          push_ready,
    input  logic [PW-1:0] push_data,
    output logic          head_valid,
    output logic [PW-1:0] head_data,
    input  logic          pop
);
    import sen_pkg::*;

    slot_state_t   state_q, state_d;
    logic [PW-1:0] slot0_q, slot1_q;
    logic          accept;

    assign accept = push_valid && push_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (accept) state_d = SLOT_ONE;
            SLOT_ONE: begin
                if (accept && !pop)      state_d = SLOT_FULL;
                else if (!accept && pop) state_d = SLOT_EMPTY;
            end
            SLOT_FULL:  if (pop) state_d = SLOT_ONE;
            default:    state_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        unique case (state_q)
            SLOT_EMPTY: if (accept) slot0_q <= push_data;
            SLOT_ONE: begin
                if (accept && pop) slot0_q <= push_data;
                else if (accept)   slot1_q <= push_data;
            end
            SLOT_FULL:  if (pop) slot0_q <= slot1_q;
            default: ;
        endcase
    end

    // Outputs depend on registered state only
    always_comb begin
        push_ready = (state_q != SLOT_FULL);
        head_valid = (state_q != SLOT_EMPTY);
        head_data  = slot0_q;
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (state_q != SLOT_EMPTY)); // R8

endmodule

// File: rtl/sen_switch.sv
module sen_switch #(
    parameter int AW    = 3,
    parameter int W     = 8,
    parameter int STAGE = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               in_valid,
    output logic [1:0]               in_ready,
    input  logic [1:0][AW+W-1:0]     in_pkt,
    output logic [1:0]               out_valid,
    input  logic [1:0]               out_ready,
    output logic [1:0][AW+W-1:0]     out_pkt
);
    import sen_pkg::*;

    localparam int PW   = AW + W;
    localparam int DBIT = W + AW - 1 - STAGE;

    logic [1:0]          hv;
    logic [1:0][PW-1:0]  hp;
    logic [1:0]          pop;
    logic [1:0][1:0]     req;
    logic [1:0]          win;
    logic [1:0]          contest;
    pref_t               pref_q, pref_d;

    for (genvar j = 0; j < 2; j++) begin : g_q
        sen_fifo2 #(.PW(PW)) u_q (
            .clk        (clk),
            .rst_n      (rst_n),
            .push_valid (in_valid[j]),
            .push_ready (in_ready[j]),
            .push_data  (in_pkt[j]),
            .head_valid (hv[j]),
            .head_data  (hp[j]),
            .pop        (pop[j])
        );
    end

    always_comb begin
        req       = '0;
        win       = '0;
        contest   = '0;
        pop       = '0;
        out_valid = '0;
        out_pkt   = '0;
        for (int o = 0; o < 2; o++) begin
            for (int i = 0; i < 2; i++)
                req[o][i] = hv[i] && (hp[i][DBIT] == 1'(o));
            contest[o] = req[o][0] && req[o][1];
            if (contest[o]) win[o] = (pref_q == PREF_LOWER);
            else            win[o] = req[o][1];
            out_valid[o] = |req[o];
            out_pkt[o]   = hp[win[o]];
            if (out_valid[o] && out_ready[o]) pop[win[o]] = 1'b1;
        end
    end

    always_comb begin
        pref_d = pref_q;
        if (|(contest & out_ready)) begin
            unique case (pref_q)
                PREF_UPPER: pref_d = PREF_LOWER;
                PREF_LOWER: pref_d = PREF_UPPER;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pref_q <= PREF_UPPER;
        else        pref_q <= pref_d;
    end

    AST_HOLD_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid[0] && !out_ready[0]) |=> out_valid[0]); // R5
    AST_HOLD_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid[1] && !out_ready[1]) |=> out_valid[1]); // R7
    AST_ROUTE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[0] |-> (out_pkt[0][DBIT] == 1'b0)); // R3
    AST_ROUTE_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[1] |-> (out_pkt[1][DBIT] == 1'b1)); // R3

endmodule

// File: rtl/sen_network.sv
module sen_network #(
    parameter int N = 8,
    parameter int W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N-1:0]             in_valid,
    output logic [N-1:0]             in_ready,
    input  logic [N*$clog2(N)-1:0]   in_dest,
    input  logic [N*W-1:0]           in_data,
    output logic [N-1:0]             out_valid,
    output logic [N*W-1:0]           out_data
);
    localparam int AW = $clog2(N);
    localparam int S  = AW;
    localparam int E  = N / 2;
    localparam int PW = AW + W;

    // Lane s feeds stage s; lane S feeds the output registers
    logic [N-1:0]  lv [S+1];
    logic [N-1:0]  lr [S+1];
    logic [PW-1:0] lp [S+1][N];

    logic [N-1:0]  out_valid_q;
    logic [N*W-1:0] out_data_q;
    logic [AW-1:0] out_dest_q [N];

    assign lv[0]    = in_valid;
    assign in_ready = lr[0];
    assign lr[S]    = '1;

    for (genvar i = 0; i < N; i++) begin : g_in
        assign lp[0][i] = {in_dest[i*AW +: AW], in_data[i*W +: W]};
    end

    for (genvar s = 0; s < S; s++) begin : g_st
        for (genvar e = 0; e < E; e++) begin : g_el
            logic [1:0]          iv, ir, ov, orr;
            logic [1:0][PW-1:0]  ip, op;
            for (genvar j = 0; j < 2; j++) begin : g_port
                localparam int SRC = sen_pkg::shuffle_src(2*e + j, AW);
                assign iv[j]          = lv[s][SRC];
                assign ip[j]          = lp[s][SRC];
                assign lr[s][SRC]     = ir[j];
                assign lv[s+1][2*e+j] = ov[j];
                assign lp[s+1][2*e+j] = op[j];
                assign orr[j]         = lr[s+1][2*e+j];
            end
            sen_switch #(.AW(AW), .W(W), .STAGE(s)) u_sw (
                .clk       (clk),
                .rst_n     (rst_n),
                .in_valid  (iv),
                .in_ready  (ir),
                .in_pkt    (ip),
                .out_valid (ov),
                .out_ready (orr),
                .out_pkt   (op)
            );
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_valid_q <= '0;
        else        out_valid_q <= lv[S];
    end

    always_ff @(posedge clk) begin
        for (int p = 0; p < N; p++) begin
            out_data_q[p*W +: W] <= lp[S][p][W-1:0];
            out_dest_q[p]        <= lp[S][p][PW-1:W];
        end
    end

    assign out_valid = out_valid_q;
    assign out_data  = out_data_q;

    for (genvar p = 0; p < N; p++) begin : g_chk
        AST_SINK_PORT: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid_q[p] |-> (out_dest_q[p] == AW'(p))); // R1
    end

endmodule

// File: tb/sim_sen_network.sv
`timescale 1ns/1ps
module sim_sen_network;
    localparam int N  = 8;
    localparam int W  = 8;
    localparam int AW = 3;
    localparam int S  = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N-1:0]     in_valid = '0;
    logic [N-1:0]     in_ready;
    logic [N*AW-1:0]  in_dest = '0;
    logic [N*W-1:0]   in_data = '0;
    logic [N-1:0]     out_valid;
    logic [N*W-1:0]   out_data;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] expq [N*N][$];
    logic [4:0]   seqn [N*N];
    logic [N-1:0] acc;
    bit           saw_stall = 0;

    always #4 clk = ~clk;

    sen_network #(.N(N), .W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_dest(in_dest), .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference scoreboard: one queue per source/destination pair, compared every clock
    always @(negedge clk) begin
        if (rst_n) begin
            for (int p = 0; p < N; p++) begin
                if (out_valid[p]) begin
                    logic [W-1:0] d;
                    int idx;
                    d   = out_data[p*W +: W];
                    idx = int'(d[7:5]) * N + p;
                    if (expq[idx].size() == 0) begin
                        chk(1'b0, "R8 unexpected packet", int'(d), 0);
                    end else begin
                        chk(d == expq[idx][0], "R8 order", int'(d), int'(expq[idx][0]));
                        void'(expq[idx].pop_front());
                    end
                end
            end
        end
    end

    task automatic load_pkt(input int i, input int d);
        int idx;
        idx = i * N + d;
        in_valid[i]            = 1'b1;
        in_dest[i*AW +: AW]    = AW'(d);
        in_data[i*W +: W]      = {3'(i), seqn[idx]};
        seqn[idx]              = seqn[idx] + 5'd1;
    endtask

    // Record handshakes in the low phase, then advance to the next falling edge
    task automatic step();
        #1;
        acc = in_valid & in_ready;
        if ((in_valid & ~in_ready) != '0) saw_stall = 1'b1;
        for (int i = 0; i < N; i++) begin
            if (acc[i])
                expq[i*N + int'(in_dest[i*AW +: AW])].push_back(in_data[i*W +: W]);
        end
        @(negedge clk);
    endtask

    task automatic route_one(input int src, input int dst);
        bit quiet;
        in_valid = '0;
        load_pkt(src, dst);
        step();
        chk(acc[src], "R4 idle input accepted", int'(acc[src]), 1);
        in_valid = '0;
        quiet = 1'b1;
        for (int k = 0; k < S; k++) begin
            if (out_valid != '0) quiet = 1'b0;
            step();
        end
        chk(quiet, "R2 early output", 0, 0);
        chk(out_valid == N'(1 << dst), "R1 R3 port select", int'(out_valid), 1 << dst);
        step();
        chk(out_valid == '0, "R2 single cycle", int'(out_valid), 0);
    endtask

    task automatic tie(input int first, input int second);
        in_valid = '0;
        load_pkt(0, 0);
        load_pkt(4, 0);
        step();
        in_valid = '0;
        for (int k = 0; k < S; k++) step();
        chk(out_valid == 8'h01 && int'(out_data[7:5]) == first, "R6 tie winner",
            int'(out_data[7:5]), first);
        step();
        chk(out_valid == 8'h01 && int'(out_data[7:5]) == second, "R7 loser retried",
            int'(out_data[7:5]), second);
        step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < N*N; i++) seqn[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == '0, "R9 outputs idle", int'(out_valid), 0);
        chk(in_ready == '1, "R9 inputs ready", int'(in_ready), 255);

        // R4: junk on dest/data with valid low must not enter
        in_dest = '1;
        in_data = '1;
        for (int k = 0; k < 6; k++) step();
        chk(out_valid == '0, "R4 invalid ignored", int'(out_valid), 0);

        for (int s = 0; s < N; s++)
            for (int d = 0; d < N; d++)
                route_one(s, d);

        tie(0, 4);   // R6 reset preference: upper wins
        tie(4, 0);   // R6 flipped
        tie(0, 4);

        // Random traffic
        in_valid = '0;
        acc = '0;
        for (int c = 0; c < 3000; c++) begin
            for (int i = 0; i < N; i++) begin
                if (in_valid[i] && !acc[i]) begin
                    // R4: hold the offered packet
                end else if ($urandom_range(99) < 45) begin
                    load_pkt(i, int'($urandom_range(N-1)));
                end else begin
                    in_valid[i] = 1'b0;
                end
            end
            step();
        end
        // Hot spot: every input aims at output 2
        saw_stall = 1'b0;
        for (int c = 0; c < 300; c++) begin
            for (int i = 0; i < N; i++)
                if (!(in_valid[i] && !acc[i])) load_pkt(i, 2);
            step();
        end
        chk(saw_stall, "R5 back-pressure seen", int'(saw_stall), 1);
        for (int c = 0; c < 600; c++) begin
            for (int i = 0; i < N; i++)
                if (!(in_valid[i] && !acc[i])) in_valid[i] = 1'b0;
            step();
        end
        begin
            int left;
            left = 0;
            for (int i = 0; i < N*N; i++) left += expq[i].size();
            chk(left == 0, "R8 all packets delivered", left, 0);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule